// File: doc/BRIEF.md
# Status Channel Diagnostic Injector

This block sits on the transmit side of a two-bit status channel and adds
diagnostic controls on top of the normal status frames. Status words and a
marker for the cycle that carries each frame's DIP-2 code enter the block. One
cycle later they leave unchanged, unless a diagnostic mode is active.

Software reaches the block through one diagnostics register. One bit holds the
channel in continuous training. A second bit, together with a count field,
corrupts the DIP-2 code of a chosen number of outgoing frames. That bit clears
itself once the last corrupted frame has gone out. A read-only field of the same
register counts the DIP-2 errors that the receive-side checker reports for the
opposite status channel. The block does not compute status content or parity;
both arrive from neighbouring logic.

Top module: `stat_diag_inject`

Register layout, with NUM_W the count-field width: bit 0 force-train; bit 1
insert; bits [NUM_W+1:2] error number; bits above that hold the received-error
count (read only). The write bus carries only the lower 2+NUM_W bits.

## Requirements
- R1: After reset the register reads zero and stat_out is 2'b00.
- R2: With training off and no injection pending, stat_out equals the stat_word presented one cycle earlier, for boundary and non-boundary words alike.
- R3: Writing the insert bit as 1 while it reads 0 loads the error number. Each later boundary word (stat_is_dip high) is sent with both bits inverted until that many frames are corrupted. At most one word per frame is corrupted, and non-boundary words pass unchanged.
- R4: The insert bit reads 0 from the cycle after the last corrupted boundary word. Later frames pass unchanged.
- R5: If the error number is zero when the insert bit is set, no word is corrupted and the insert bit clears at the next boundary word.
- R6: While the force-train bit (bit 0) is 1, stat_out carries the training pattern: ZERO_LEN words of 2'b00 then ONE_LEN words of 2'b11, repeating. The first output after the bit is set is the first 2'b00 word.
- R7: Training has priority over injection. While training is forced, no word is corrupted and the remaining injection count is held. Writing insert as 1 while it already reads 1 keeps the remaining count. After training is released, the remaining frames are corrupted.
- R8: Each rx_dip_err pulse adds one to the received-error count. The count saturates at its all-ones value.
- R9: The force-train bit and the error-number field read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NUM_W+2 | Write data for the writable fields |
| reg_rdata | output | NUM_W+2+CNT_W | Register read view |
| stat_word | input | 2 | Outgoing status word from the status source |
| stat_is_dip | input | 1 | High on the word that carries a frame's DIP-2 code |
| rx_dip_err | input | 1 | One-cycle pulse per DIP-2 error seen on the receive channel |
| stat_out | output | 2 | Status word to the channel, registered |

## Verification
The bench uses a 3-bit error number and a 4-bit count. The count therefore
reaches saturation after fifteen pulses, and injection runs of several frames
stay short. The training pattern is shortened to two 2'b00 words and three
2'b11 words. The bench can then cover more than one full period and a forced
stretch that overlaps several frame boundaries, which exercises the held
injection count.

// File: rtl/stat_diag_pkg.sv
package stat_diag_pkg;

    localparam int STAT_W = 2;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t TRAIN_LO = 2'b00;
    localparam stat_t TRAIN_HI = 2'b11;

    localparam int BIT_FORCE  = 0;
    localparam int BIT_INSERT = 1;
    localparam int NUM_LSB    = 2;

    typedef enum logic [1:0] {
        OSEL_PASS  = 2'd0,
        OSEL_FLIP  = 2'd1,
        OSEL_TRAIN = 2'd2
    } osel_e;

    function automatic stat_t train_code(input logic in_low_run);
        return in_low_run ? TRAIN_LO : TRAIN_HI;
    endfunction

    function automatic stat_t apply_sel(input osel_e sel, input stat_t word,
                                        input stat_t train);
        case (sel)
            OSEL_FLIP:  return ~word;
            OSEL_TRAIN: return train;
            default:    return word;
        endcase
    endfunction

endpackage

// File: rtl/stat_diag_regs.sv
module stat_diag_regs
    import stat_diag_pkg::*;
#(
    parameter int NUM_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [NUM_W+1:0] wdata,
    input  logic             done,
    output logic             force_o,
    output logic             insert_o,
    output logic [NUM_W-1:0] num_o,
    output logic             load_o,
    output logic [NUM_W-1:0] load_num_o
);

    logic             force_q;
    logic             insert_q;
    logic [NUM_W-1:0] num_q;
    logic             wr_insert;

    assign wr_insert  = wdata[BIT_INSERT];
    assign load_o     = wr && wr_insert && !insert_q;
    assign load_num_o = wdata[NUM_LSB +: NUM_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= 1'b0;
            num_q   <= '0;
        end else if (wr) begin
            force_q <= wdata[BIT_FORCE];
            num_q   <= wdata[NUM_LSB +: NUM_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            insert_q <= 1'b0;
        end else if (wr && !wr_insert) begin
            insert_q <= 1'b0;
        end else if (load_o) begin
            insert_q <= 1'b1;
        end else if (done) begin
            insert_q <= 1'b0;
        end
    end

    assign force_o  = force_q;
    assign insert_o = insert_q;
    assign num_o    = num_q;

endmodule

// File: rtl/stat_inject_ctl.sv
module stat_inject_ctl #(
    parameter int NUM_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] load_num,
    input  logic             insert,
    input  logic             force_train,
    input  logic             frm_dip,
    output logic             flip,
    output logic             done,
    output logic [NUM_W-1:0] rem_o
);

    logic [NUM_W-1:0] rem_q;
    logic             at_boundary;
    logic             last_one;

    assign at_boundary = insert && !force_train && frm_dip;
    assign last_one    = (rem_q <= NUM_W'(1));
    assign flip        = at_boundary && (rem_q != '0);
    assign done        = at_boundary && last_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_num;
        end else if (flip) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/stat_train_gen.sv
module stat_train_gen
    import stat_diag_pkg::*;
#(
    parameter int ZERO_LEN = 10,
    parameter int ONE_LEN  = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output stat_t code
);

    localparam int PERIOD = ZERO_LEN + ONE_LEN;
    localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q <= '0;
        end else if (pos_q == PW'(PERIOD - 1)) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign code = train_code(pos_q < PW'(ZERO_LEN));

endmodule

// File: rtl/stat_err_tally.sv
module stat_err_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hit && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/stat_diag_inject.sv
module stat_diag_inject
    import stat_diag_pkg::*;
#(
    parameter int NUM_W    = 6,
    parameter int CNT_W    = 8,
    parameter int ZERO_LEN = 10,
    parameter int ONE_LEN  = 10,
    localparam int WR_W    = NUM_W + 2,
    localparam int REG_W   = WR_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [WR_W-1:0]  reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [1:0]       stat_word,
    input  logic             stat_is_dip,
    input  logic             rx_dip_err,
    output logic [1:0]       stat_out
);

    logic             force_q;
    logic             insert_q;
    logic [NUM_W-1:0] num_q;
    logic             load;
    logic [NUM_W-1:0] load_num;
    logic             flip;
    logic             done;
    logic [NUM_W-1:0] rem_q;
    logic [CNT_W-1:0] err_cnt;
    stat_t            train;
    osel_e            sel;
    stat_t            out_q;

    stat_diag_regs #(.NUM_W(NUM_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .done       (done),
        .force_o    (force_q),
        .insert_o   (insert_q),
        .num_o      (num_q),
        .load_o     (load),
        .load_num_o (load_num)
    );

    stat_inject_ctl #(.NUM_W(NUM_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_num    (load_num),
        .insert      (insert_q),
        .force_train (force_q),
        .frm_dip     (stat_is_dip),
        .flip        (flip),
        .done        (done),
        .rem_o       (rem_q)
    );

    stat_train_gen #(.ZERO_LEN(ZERO_LEN), .ONE_LEN(ONE_LEN)) u_train (
        .clk  (clk),
        .rst  (rst),
        .run  (force_q),
        .code (train)
    );

    stat_err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .hit   (rx_dip_err),
        .count (err_cnt)
    );

    always_comb begin
        if (force_q)   sel = OSEL_TRAIN;
        else if (flip) sel = OSEL_FLIP;
        else           sel = OSEL_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= apply_sel(sel, stat_word, train);
        end
    end

    assign stat_out  = out_q;
    assign reg_rdata = {err_cnt, num_q, insert_q, force_q};

endmodule

// File: rtl/stat_diag_inject_chk.sv
module stat_diag_inject_chk #(
    parameter int NUM_W = 6,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       stat_word,
    input logic             stat_is_dip,
    input logic [1:0]       stat_out,
    input logic             reg_wr,
    input logic             rx_dip_err,
    input logic             force_q,
    input logic             insert_q,
    input logic             load,
    input logic [NUM_W-1:0] rem_q,
    input logic [CNT_W-1:0] err_cnt
);

    // R2: a non-boundary word with training off passes unchanged
    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(force_q) && !$past(stat_is_dip))
            |-> (stat_out == $past(stat_word)));

    // R3: a changed word outside training only follows a boundary word
    a_r3_flip_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(force_q) && (stat_out != $past(stat_word)))
            |-> $past(stat_is_dip));

    // R4: the insert bit drops only on a write or at a boundary outside training
    a_r4_clear_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(insert_q))
            |-> ($past(reg_wr) || ($past(stat_is_dip) && !$past(force_q))));

    // R6: training output uses only the two training codes
    a_r6_train_code: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(force_q))
            |-> ((stat_out == 2'b00) || (stat_out == 2'b11)));

    // R7: the remaining count is held while training is forced
    a_r7_rem_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(force_q) && !$past(load)) |-> $stable(rem_q));

    // R8: one step per pulse below the maximum
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (rx_dip_err && (err_cnt != '1)) |=> (err_cnt == $past(err_cnt) + 1'b1));

    // R8: the count holds at its maximum
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (err_cnt == '1) |=> (err_cnt == '1));

endmodule

bind stat_diag_inject stat_diag_inject_chk #(.NUM_W(NUM_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stat_word   (stat_word),
    .stat_is_dip (stat_is_dip),
    .stat_out    (stat_out),
    .reg_wr      (reg_wr),
    .rx_dip_err  (rx_dip_err),
    .force_q     (force_q),
    .insert_q    (insert_q),
    .load        (load),
    .rem_q       (rem_q),
    .err_cnt     (err_cnt)
);

// File: tb/test_stat_diag_inject.sv
module test_stat_diag_inject;

    localparam int NUM_W  = 3;
    localparam int CNT_W  = 4;
    localparam int ZL     = 2;
    localparam int OL     = 3;
    localparam int PER    = ZL + OL;
    localparam int WR_W   = NUM_W + 2;
    localparam int REG_W  = WR_W + CNT_W;
    localparam int CNT_LO = WR_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [WR_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic [1:0]       stat_word = 2'b00;
    logic             stat_is_dip = 1'b0;
    logic             rx_dip_err = 1'b0;
    logic [1:0]       stat_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    stat_diag_inject #(.NUM_W(NUM_W), .CNT_W(CNT_W), .ZERO_LEN(ZL), .ONE_LEN(OL))
        i_stat_diag_inject (
            .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
            .reg_rdata(reg_rdata), .stat_word(stat_word), .stat_is_dip(stat_is_dip),
            .rx_dip_err(rx_dip_err), .stat_out(stat_out));

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit frc, input bit ins, input int num);
        stat_is_dip = 1'b0;
        reg_wdata = {NUM_W'(num), ins, frc};
        reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [1:0] w, input bit dip, input bit flip, input string req);
        stat_word = w;
        stat_is_dip = dip;
        step();
        chk(stat_out == (flip ? ~w : w), req, stat_out, flip ? ~w : w);
        stat_is_dip = 1'b0;
    endtask

    task automatic frame(input bit flip, input string req);
        send(2'b10, 1'b0, 1'b0, req);
        send(2'b11, 1'b0, 1'b0, req);
        send(2'b00, 1'b0, 1'b0, req);
        send(2'b01, 1'b1, flip, req);
    endtask

    function automatic logic [1:0] pat(input int k);
        return ((k % PER) < ZL) ? 2'b00 : 2'b11;
    endfunction

    task automatic t_reset();
        chk(reg_rdata == '0, "R1 register", reg_rdata, 0);
        chk(stat_out == 2'b00, "R1 stat_out", stat_out, 0);
    endtask

    task automatic t_pass();
        send(2'b01, 1'b0, 1'b0, "R2");
        send(2'b10, 1'b1, 1'b0, "R2");
        send(2'b11, 1'b0, 1'b0, "R2");
        send(2'b00, 1'b1, 1'b0, "R2");
        frame(1'b0, "R2");
    endtask

    task automatic t_inject();
        wr_reg(1'b0, 1'b1, 3);
        chk(reg_rdata[1] == 1'b1, "R3 insert set", reg_rdata[1], 1);
        chk(reg_rdata[WR_W-1:2] == 3, "R9 num readback", reg_rdata[WR_W-1:2], 3);
        frame(1'b1, "R3");
        frame(1'b1, "R3");
        chk(reg_rdata[1] == 1'b1, "R3 insert still set", reg_rdata[1], 1);
        frame(1'b1, "R3");
        chk(reg_rdata[1] == 1'b0, "R4 insert cleared", reg_rdata[1], 0);
        frame(1'b0, "R4");
        frame(1'b0, "R4");
    endtask

    task automatic t_zero();
        wr_reg(1'b0, 1'b1, 0);
        chk(reg_rdata[1] == 1'b1, "R5 insert set", reg_rdata[1], 1);
        frame(1'b0, "R5");
        chk(reg_rdata[1] == 1'b0, "R5 insert cleared", reg_rdata[1], 0);
        frame(1'b0, "R5");
    endtask

    task automatic t_train();
        wr_reg(1'b1, 1'b0, 5);
        chk(reg_rdata[0] == 1'b1, "R9 force readback", reg_rdata[0], 1);
        for (int k = 0; k < 2 * PER + 1; k++) begin
            stat_word = 2'(k);
            stat_is_dip = (k % 3 == 2);
            step();
            chk(stat_out == pat(k), "R6 pattern", stat_out, pat(k));
        end
        stat_is_dip = 1'b0;
        wr_reg(1'b0, 1'b0, 0);
        step();
        frame(1'b0, "R6 release");
    endtask

    task automatic t_prio();
        wr_reg(1'b0, 1'b1, 2);
        frame(1'b1, "R7 first");
        wr_reg(1'b1, 1'b1, 2);
        for (int k = 0; k < 8; k++) begin
            stat_word = 2'b01;
            stat_is_dip = (k % 2 == 1);
            step();
            chk(stat_out == pat(k), "R7 training wins", stat_out, pat(k));
        end
        stat_is_dip = 1'b0;
        chk(reg_rdata[1] == 1'b1, "R7 insert held", reg_rdata[1], 1);
        wr_reg(1'b0, 1'b1, 2);
        step();
        frame(1'b1, "R7 resumed");
        chk(reg_rdata[1] == 1'b0, "R7 insert cleared", reg_rdata[1], 0);
        frame(1'b0, "R7 after");
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            rx_dip_err = 1'b1;
            step();
            rx_dip_err = 1'b0;
            step();
        end
    endtask

    task automatic t_count();
        pulse(3);
        chk(reg_rdata[REG_W-1:CNT_LO] == 3, "R8 count", reg_rdata[REG_W-1:CNT_LO], 3);
        pulse(11);
        chk(reg_rdata[REG_W-1:CNT_LO] == 14, "R8 count", reg_rdata[REG_W-1:CNT_LO], 14);
        pulse(1);
        chk(reg_rdata[REG_W-1:CNT_LO] == 15, "R8 max", reg_rdata[REG_W-1:CNT_LO], 15);
        pulse(4);
        chk(reg_rdata[REG_W-1:CNT_LO] == 15, "R8 saturate", reg_rdata[REG_W-1:CNT_LO], 15);
    endtask

    initial begin
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_pass();
        t_inject();
        t_zero();
        t_train();
        t_prio();
        t_count();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule